// File: doc/BRIEF.md
# Low-Power Clock Gating Controller

This block decides which oscillators and which clock branches run. Its inputs are four low-power control bits and a source selection for each of the three clocks: the main (CPU) clock, the sub clock for peripherals and the auxiliary clock. The four bits are cpu halt, sub gate, bias off and low-frequency off. Its outputs enable the main and sub clock branches, the fast oscillator, the fast oscillator's bias (DC) generator, the external crystal oscillator and the internal low-power oscillator. Software writes all control fields at once with a write strobe. Wake-up is modelled as a write that clears control bits.

Interlocks keep an oscillator running while a clock branch that is still enabled draws on it. This holds whatever the gating bits say. A restarted fast oscillator is not passed to any branch until a fixed startup delay, counted in reference ticks, has run out, so the branch never sees the oscillator's erratic first pulses. A branch enable changes only while the ungated clock level of that branch is low, so gating never clips a pulse.

Top module: `lp_clk_ctrl`

## Requirements
- R1: Reset clears all four control bits, selects the fast oscillator for main and sub clocks and the crystal for the auxiliary clock. During reset the fast oscillator, bias and crystal enables are high, the low-power oscillator enable is low and both branch enables are low.
- R2: A branch sourced from the fast oscillator stays disabled for START_TICKS rising edges after the fast oscillator enable rises. It is enabled on the next rising edge that samples its level input low.
- R3: A set cpu halt bit disables the main branch, and a set sub gate bit disables the sub branch.
- R4: The fast oscillator stays enabled while an enabled branch selects it, even with sub gate and bias off set. Its bias generator is then also kept on.
- R5: The fast oscillator is off when no requested or still-enabled branch selects it. Its bias generator is off when, in addition, bias off is set.
- R6: With low-frequency off clear, the oscillator named by the auxiliary select runs (0 = crystal, 1 = low-power). With it set, a low-frequency oscillator runs only while it sources a requested or enabled main or sub branch.
- R7: A branch enable changes only on a rising edge that samples the branch level input low. While that input is high the enable holds.
- R8: Control inputs are ignored unless the write strobe is high on a rising edge.
- R9: Source select encoding for main and sub: 2'b00 and 2'b01 fast oscillator, 2'b10 crystal, 2'b11 low-power oscillator. A branch on a low-frequency source is enabled one edge after being requested.
- R10: With all control bits clear, both branches and every selected oscillator run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference tick clock, always running |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for all control fields |
| cpu_halt_i | input | 1 | Main branch gate request |
| sub_gate_i | input | 1 | Sub branch gate request |
| bias_off_i | input | 1 | Fast oscillator bias generator off request |
| lf_off_i | input | 1 | Low-frequency oscillators off request |
| main_sel_i | input | 2 | Main clock source select |
| sub_sel_i | input | 2 | Sub clock source select |
| aux_sel_i | input | 1 | Auxiliary clock source: 0 crystal, 1 low-power |
| main_lvl_i | input | 1 | Ungated main clock level |
| sub_lvl_i | input | 1 | Ungated sub clock level |
| main_en_o | output | 1 | Main branch enable |
| sub_en_o | output | 1 | Sub branch enable |
| fosc_en_o | output | 1 | Fast oscillator enable |
| bias_en_o | output | 1 | Fast oscillator bias generator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| lpo_en_o | output | 1 | Internal low-power oscillator enable |

## Verification
The hardest case to reach is a branch that has just been gated off while its clock level is still high. The enable is held at that point, and the fast oscillator must stay on only because the stale enable still draws on it. The bench holds the main level input high and then writes the halt bit. It checks that the enable and the fast oscillator both persist. It then drops the level and checks that both fall together. A restart is forced by first moving the main clock to the crystal with the sub branch gated, which lets the startup counter clear. The main clock is then moved back, and the edge count is checked on both sides of the delay.

// File: rtl/lp_clk_pkg.sv
package lp_clk_pkg;
  localparam int unsigned NUM_BR = 2;
  localparam int unsigned BR_MAIN = 0;
  localparam int unsigned BR_SUB = 1;

  typedef enum logic [1:0] {
    SRC_FAST0 = 2'b00,
    SRC_FAST1 = 2'b01,
    SRC_XTAL  = 2'b10,
    SRC_LPO   = 2'b11
  } src_e;

  typedef struct packed {
    logic halt;
    logic sub_gate;
    logic bias_off;
    logic lf_off;
  } lp_ctrl_t;

  function automatic logic src_is_fast(src_e s);
    return (s == SRC_FAST0) || (s == SRC_FAST1);
  endfunction
endpackage

// File: rtl/lp_cfg_regs.sv
module lp_cfg_regs
  import lp_clk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  lp_ctrl_t ctrl_i,
  input  src_e     main_sel_i,
  input  src_e     sub_sel_i,
  input  logic     aux_sel_i,
  output lp_ctrl_t ctrl_o,
  output src_e     main_sel_o,
  output src_e     sub_sel_o,
  output logic     aux_sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      main_sel_o <= SRC_FAST0;
      sub_sel_o  <= SRC_FAST0;
      aux_sel_o  <= 1'b0;
    end else if (we_i) begin
      ctrl_o     <= ctrl_i;
      main_sel_o <= main_sel_i;
      sub_sel_o  <= sub_sel_i;
      aux_sel_o  <= aux_sel_i;
    end
  end
endmodule

// File: rtl/lp_src_arbiter.sv
module lp_src_arbiter
  import lp_clk_pkg::*;
(
  input  lp_ctrl_t          ctrl_i,
  input  src_e              br_sel_i [NUM_BR],
  input  logic              aux_sel_i,
  input  logic [NUM_BR-1:0] br_en_i,
  output logic [NUM_BR-1:0] br_want_o,
  output logic              fosc_en_o,
  output logic              bias_en_o,
  output logic              xtal_en_o,
  output logic              lpo_en_o
);
  logic [NUM_BR-1:0] use_fast, use_xtal, use_lpo;

  always_comb begin
    br_want_o[BR_MAIN] = !ctrl_i.halt;
    br_want_o[BR_SUB]  = !ctrl_i.sub_gate;
  end

  // a branch draws on its source while requested or while its enable is still high
  for (genvar b = 0; b < NUM_BR; b++) begin : g_use
    logic active;
    assign active      = br_want_o[b] || br_en_i[b];
    assign use_fast[b] = active && src_is_fast(br_sel_i[b]);
    assign use_xtal[b] = active && (br_sel_i[b] == SRC_XTAL);
    assign use_lpo[b]  = active && (br_sel_i[b] == SRC_LPO);
  end

  always_comb begin
    fosc_en_o = |use_fast;
    bias_en_o = !ctrl_i.bias_off || fosc_en_o;
    xtal_en_o = (|use_xtal) || (!ctrl_i.lf_off && !aux_sel_i);
    lpo_en_o  = (|use_lpo)  || (!ctrl_i.lf_off &&  aux_sel_i);
  end
endmodule

// File: rtl/lp_fosc_startup.sv
module lp_fosc_startup #(
  parameter int unsigned START_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fosc_en_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(START_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(START_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!fosc_en_i)      cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = fosc_en_i && (cnt_q == LIMIT);
endmodule

// File: rtl/lp_branch_gate.sv
module lp_branch_gate
  import lp_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  src_e sel_i,
  input  logic fosc_ready_i,
  input  logic xtal_en_i,
  input  logic lpo_en_i,
  input  logic lvl_i,
  output logic en_o
);
  logic src_ok, target;

  always_comb begin
    unique case (sel_i)
      SRC_XTAL: src_ok = xtal_en_i;
      SRC_LPO:  src_ok = lpo_en_i;
      default:  src_ok = fosc_ready_i;
    endcase
    target = want_i && src_ok;
  end

  // update only in the low phase of the ungated clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_o <= 1'b0;
    else if (!lvl_i) en_o <= target;
  end
endmodule

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl
  import lp_clk_pkg::*;
#(
  parameter int unsigned START_TICKS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic       cpu_halt_i,
  input  logic       sub_gate_i,
  input  logic       bias_off_i,
  input  logic       lf_off_i,
  input  logic [1:0] main_sel_i,
  input  logic [1:0] sub_sel_i,
  input  logic       aux_sel_i,
  input  logic       main_lvl_i,
  input  logic       sub_lvl_i,
  output logic       main_en_o,
  output logic       sub_en_o,
  output logic       fosc_en_o,
  output logic       bias_en_o,
  output logic       xtal_en_o,
  output logic       lpo_en_o
);
  lp_ctrl_t ctrl_in, ctrl_q;
  src_e main_sel_q, sub_sel_q;
  logic aux_sel_q;
  src_e br_sel [NUM_BR];
  logic [NUM_BR-1:0] br_want, br_en, br_lvl;
  logic fosc_ready;

  assign ctrl_in = '{halt: cpu_halt_i, sub_gate: sub_gate_i,
                     bias_off: bias_off_i, lf_off: lf_off_i};

  lp_cfg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .ctrl_i     (ctrl_in),
    .main_sel_i (src_e'(main_sel_i)),
    .sub_sel_i  (src_e'(sub_sel_i)),
    .aux_sel_i  (aux_sel_i),
    .ctrl_o     (ctrl_q),
    .main_sel_o (main_sel_q),
    .sub_sel_o  (sub_sel_q),
    .aux_sel_o  (aux_sel_q)
  );

  assign br_sel[BR_MAIN] = main_sel_q;
  assign br_sel[BR_SUB]  = sub_sel_q;
  assign br_lvl = {sub_lvl_i, main_lvl_i};

  lp_src_arbiter u_arb (
    .ctrl_i    (ctrl_q),
    .br_sel_i  (br_sel),
    .aux_sel_i (aux_sel_q),
    .br_en_i   (br_en),
    .br_want_o (br_want),
    .fosc_en_o (fosc_en_o),
    .bias_en_o (bias_en_o),
    .xtal_en_o (xtal_en_o),
    .lpo_en_o  (lpo_en_o)
  );

  lp_fosc_startup #(.START_TICKS(START_TICKS)) u_start (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fosc_en_i (fosc_en_o),
    .ready_o   (fosc_ready)
  );

  for (genvar b = 0; b < NUM_BR; b++) begin : g_br
    lp_branch_gate u_gate (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .want_i       (br_want[b]),
      .sel_i        (br_sel[b]),
      .fosc_ready_i (fosc_ready),
      .xtal_en_i    (xtal_en_o),
      .lpo_en_i     (lpo_en_o),
      .lvl_i        (br_lvl[b]),
      .en_o         (br_en[b])
    );
  end

  assign main_en_o = br_en[BR_MAIN];
  assign sub_en_o  = br_en[BR_SUB];
endmodule

// File: rtl/lp_clk_ctrl_chk.sv
module lp_clk_ctrl_chk #(
  parameter int unsigned START_TICKS = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_q,
  input logic [1:0] main_sel_q,
  input logic [1:0] sub_sel_q,
  input logic       main_lvl_i,
  input logic       main_en_o,
  input logic       sub_en_o,
  input logic       fosc_en_o,
  input logic       bias_en_o,
  input logic       xtal_en_o
);
  localparam int unsigned CW = $clog2(START_TICKS + 2);
  localparam logic [CW-1:0] SAT = CW'(START_TICKS + 1);

  logic [CW-1:0] run_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_cnt <= '0;
    else if (!fosc_en_o)      run_cnt <= '0;
    else if (run_cnt != SAT)  run_cnt <= run_cnt + 1'b1;
  end

  a_r2_startup_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(main_en_o) && !main_sel_q[1]) |-> (run_cnt >= CW'(START_TICKS)));

  a_r3_halt_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !main_lvl_i) |=> !main_en_o);

  a_r4_fast_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((main_en_o && !main_sel_q[1]) || (sub_en_o && !sub_sel_q[1])) |-> fosc_en_o);

  a_r4_bias_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fosc_en_o |-> bias_en_o);

  a_r6_xtal_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_en_o && main_sel_q == 2'b10) |-> xtal_en_o);

  a_r7_hold_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_lvl_i |=> $stable(main_en_o));
endmodule

bind lp_clk_ctrl lp_clk_ctrl_chk #(.START_TICKS(START_TICKS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halt_q     (ctrl_q.halt),
  .main_sel_q (main_sel_q),
  .sub_sel_q  (sub_sel_q),
  .main_lvl_i (main_lvl_i),
  .main_en_o  (main_en_o),
  .sub_en_o   (sub_en_o),
  .fosc_en_o  (fosc_en_o),
  .bias_en_o  (bias_en_o),
  .xtal_en_o  (xtal_en_o)
);

// File: tb/sim_lp_clk_ctrl.sv
`timescale 1ns/1ps
module sim_lp_clk_ctrl;
  localparam int unsigned S = 8;
  localparam int NV = 8;
  // {halt,sub_gate,bias_off,lf_off, main_sel, sub_sel, aux_sel, exp main,sub,fosc,bias,xtal,lpo}
  localparam logic [14:0] VEC [NV] = '{
    15'b0000_00_00_0_111110,
    15'b0000_10_11_0_110111,
    15'b0110_00_00_1_101101,
    15'b1111_00_00_0_000000,
    15'b0111_10_00_1_100010,
    15'b0011_11_10_0_110011,
    15'b1010_00_01_1_011101,
    15'b0000_01_01_0_111110
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, cpu_halt_i = 1'b0, sub_gate_i = 1'b0;
  logic bias_off_i = 1'b0, lf_off_i = 1'b0, aux_sel_i = 1'b0;
  logic [1:0] main_sel_i = 2'b00, sub_sel_i = 2'b00;
  logic main_lvl_i = 1'b0, sub_lvl_i = 1'b0;
  logic main_en_o, sub_en_o, fosc_en_o, bias_en_o, xtal_en_o, lpo_en_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  lp_clk_ctrl #(.START_TICKS(S)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i),
    .cpu_halt_i(cpu_halt_i), .sub_gate_i(sub_gate_i),
    .bias_off_i(bias_off_i), .lf_off_i(lf_off_i),
    .main_sel_i(main_sel_i), .sub_sel_i(sub_sel_i), .aux_sel_i(aux_sel_i),
    .main_lvl_i(main_lvl_i), .sub_lvl_i(sub_lvl_i),
    .main_en_o(main_en_o), .sub_en_o(sub_en_o), .fosc_en_o(fosc_en_o),
    .bias_en_o(bias_en_o), .xtal_en_o(xtal_en_o), .lpo_en_o(lpo_en_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic [5:0] e);
    chk(req, "main_en", main_en_o, e[5]);
    chk(req, "sub_en",  sub_en_o,  e[4]);
    chk(req, "fosc_en", fosc_en_o, e[3]);
    chk(req, "bias_en", bias_en_o, e[2]);
    chk(req, "xtal_en", xtal_en_o, e[1]);
    chk(req, "lpo_en",  lpo_en_o,  e[0]);
  endtask

  task automatic wr(input logic [8:0] c);
    @(negedge clk);
    {cpu_halt_i, sub_gate_i, bias_off_i, lf_off_i, main_sel_i, sub_sel_i, aux_sel_i} = c;
    cfg_we_i = 1'b1;
    @(posedge clk); #2;
    cfg_we_i = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    #35;
    outs("R1", 6'b001110);
    @(negedge clk); rst_ni = 1'b1;
    // R2 startup after reset
    step(S);
    chk("R2", "main_en before delay", main_en_o, 1'b0);
    step(1);
    chk("R2", "main_en after delay", main_en_o, 1'b1);
    chk("R2", "sub_en after delay", sub_en_o, 1'b1);

    // table: R3 R4 R5 R6 R9 R10
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][14:6]);
      step(S + 3);
      outs($sformatf("R3/R4/R5/R6/R9/R10 row%0d", i), VEC[i][5:0]);
    end

    // R2 restart: stop fast osc, then reselect it for main
    wr(9'b0110_10_00_0);
    step(3);
    chk("R5", "fosc off when unused", fosc_en_o, 1'b0);
    chk("R9", "main on crystal", main_en_o, 1'b1);
    wr(9'b0110_00_00_0);
    chk("R4", "fosc restarts", fosc_en_o, 1'b1);
    step(1);
    chk("R2", "main off while starting", main_en_o, 1'b0);
    step(S - 1);
    chk("R2", "main still off at delay", main_en_o, 1'b0);
    step(1);
    chk("R2", "main on after delay", main_en_o, 1'b1);

    // R7: halt while main level high
    main_lvl_i = 1'b1;
    wr(9'b1110_00_00_0);
    step(3);
    chk("R7", "main held while high", main_en_o, 1'b1);
    chk("R4", "fosc kept by stale enable", fosc_en_o, 1'b1);
    @(negedge clk); main_lvl_i = 1'b0;
    step(1);
    chk("R7", "main off at low phase", main_en_o, 1'b0);
    chk("R5", "fosc off after gating", fosc_en_o, 1'b0);
    chk("R5", "bias off", bias_en_o, 1'b0);

    // R8: inputs without strobe ignored
    @(negedge clk);
    cpu_halt_i = 1'b0; sub_gate_i = 1'b0; bias_off_i = 1'b0;
    step(S + 3);
    chk("R8", "main unchanged", main_en_o, 1'b0);
    chk("R8", "sub unchanged", sub_en_o, 1'b0);
    chk("R8", "fosc unchanged", fosc_en_o, 1'b0);

    // R1 reset mid-run, then R2 delay again
    @(negedge clk); rst_ni = 1'b0;
    #2;
    outs("R1 mid-run", 6'b001110);
    @(negedge clk); rst_ni = 1'b1;
    step(S);
    chk("R2", "main before delay", main_en_o, 1'b0);
    step(1);
    chk("R2", "main after delay", main_en_o, 1'b1);
    chk("R1", "lpo off after reset", lpo_en_o, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule